// File: doc/BRIEF.md
# Logical Device Resource Register Set

This block is the per-logical-device register bank that sits behind a plug-and-play configuration controller. It holds one enable bit, which puts the device on the bus, and a conflict-test control. It also holds a set of I/O base addresses, two interrupt descriptors and two DMA descriptors. The controller reaches all of them through an 8-bit index and a write or read strobe. Read data comes back one cycle later.

On the host side, the block compares every host I/O read against the programmed port windows. While the device is enabled, a hit raises a device-select for the device's real function. While the device is disabled and conflict testing is switched on, the block answers the hit itself with a fixed byte, 0x55 or 0xAA. Software can then tell whether some other agent also decodes that range. A pulse on the configuration reset input returns every register to its power-up value.

Top module: `ldev_resource_regs`

## Requirements
- R1: After the synchronous reset every register reads as zero, except the two DMA descriptors, which read 4. `dev_sel`, `host_rdata_oe`, `host_rdata`, `cfg_rdata` and `dev_active` are all low.
- R2: Index 0x30 stores write-data bit 0 as the enable bit, which is visible on `dev_active`. Bits 7:1 read back as zero.
- R3: Index 0x31 stores bit 1 (conflict test on) and bit 0 (pattern select: 1 gives 0x55, 0 gives 0xAA). Bits 7:2 read back as zero.
- R4: I/O range n (0..7) keeps base bits 15:8 at index 0x60+2n and base bits 7:0 at index 0x61+2n. All eight bits of each byte read back.
- R5: Interrupt entry m (0..1) keeps its level in bits 3:0 of index 0x70+2m, with bits 7:4 reading zero. It keeps polarity (bit 1) and trigger type (bit 0) at index 0x71+2m, with bits 7:2 reading zero.
- R6: DMA entry k (0..1) keeps a channel number in bits 2:0 of index 0x74+k, with bits 7:3 reading zero. The value 4 means no channel.
- R7: A write to any other index changes nothing, and a read of any other index returns zero.
- R8: A host read hits range n when that range's base is non-zero and host address bits 15:3 equal base bits 15:3, which gives an aligned 8-port window. A base of zero never hits. Without a host read strobe there is no response.
- R9: A hit while the device is enabled raises `dev_sel` in the next cycle, and the block does not drive data. This holds even when conflict testing is on.
- R10: A hit while the device is disabled and conflict testing is on raises `host_rdata_oe` in the next cycle, with `host_rdata` = 0x55 or 0xAA according to the pattern select. `host_rdata` is zero whenever `host_rdata_oe` is low.
- R11: A hit while the device is disabled and conflict testing is off produces no select and no data.
- R12: `cfg_reset` restores every register to its R1 value. It takes priority over a write in the same cycle.
- R13: `cfg_rdata` shows the addressed register in the cycle after `cfg_rd` and is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reset | input | 1 | Configuration reset pulse, restores power-up values |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, one cycle after `cfg_rd` |
| host_rd | input | 1 | Host I/O read strobe |
| host_addr | input | 16 | Host I/O address |
| dev_sel | output | 1 | Enabled device decoded the previous host read |
| host_rdata_oe | output | 1 | Block drives a conflict-test byte |
| host_rdata | output | 8 | Conflict-test byte |
| dev_active | output | 1 | Enable bit |

## Verification
The bench probes the window edges one port below and one port past an aligned range. A decoder that compares too many or too few address bits would hit on 0x1238 or miss on 0x1237. It also reads address zero while six ranges still hold a zero base, which catches a design that lets an unprogrammed range match. It enables the device with conflict testing still on: a design that ignores the enable bit in that case would drive 0x55 onto a live device. It pulses the configuration reset together with a write, and reads the DMA descriptors afterwards. A design that lets the write win, or that clears the DMA channel to 0 instead of 4, would show up there.

// File: rtl/ldev_pkg.sv
package ldev_pkg;

  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int BASE_W = 16;

  // Register index map: the offsets are fixed by the configuration protocol.
  localparam logic [IDX_W-1:0] IDX_ACT  = 8'h30;
  localparam logic [IDX_W-1:0] IDX_RCHK = 8'h31;
  localparam logic [IDX_W-1:0] IDX_IO   = 8'h60;
  localparam logic [IDX_W-1:0] IDX_IRQ  = 8'h70;
  localparam logic [IDX_W-1:0] IDX_DMA  = 8'h74;

  localparam logic [DATA_W-1:0] PAT_ONE  = 8'h55;
  localparam logic [DATA_W-1:0] PAT_ZERO = 8'hAA;
  localparam logic [2:0]        DMA_NONE = 3'd4;

  typedef struct packed {
    logic [3:0] level;
    logic       pol_high;
    logic       lvl_trig;
  } irq_cfg_t;

endpackage

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_reset,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic                          active,
  output logic                          rc_en,
  output logic                          rc_one,
  output logic [NUM_IO-1:0][BASE_W-1:0] io_base
);

  logic                          act_q;
  logic                          rc_en_q;
  logic                          rc_one_q;
  logic [NUM_IO-1:0][BASE_W-1:0] base_q;
  irq_cfg_t                      irq_q [NUM_IRQ];
  logic [2:0]                    dma_q [NUM_DMA];
  logic [DATA_W-1:0]             rd_val;
  logic [DATA_W-1:0]             rdata_q;

  // Write side; the configuration reset wins over a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst || cfg_reset) begin
      act_q    <= 1'b0;
      rc_en_q  <= 1'b0;
      rc_one_q <= 1'b0;
      base_q   <= '0;
      for (int i = 0; i < NUM_IRQ; i++) irq_q[i] <= '0;
      for (int k = 0; k < NUM_DMA; k++) dma_q[k] <= DMA_NONE;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_ACT) act_q <= cfg_wdata[0];
      if (cfg_idx == IDX_RCHK) begin
        rc_en_q  <= cfg_wdata[1];
        rc_one_q <= cfg_wdata[0];
      end
      for (int i = 0; i < NUM_IO; i++) begin
        if (cfg_idx == IDX_W'(IDX_IO + 2*i))     base_q[i][15:8] <= cfg_wdata;
        if (cfg_idx == IDX_W'(IDX_IO + 2*i + 1)) base_q[i][7:0]  <= cfg_wdata;
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (cfg_idx == IDX_W'(IDX_IRQ + 2*i)) irq_q[i].level <= cfg_wdata[3:0];
        if (cfg_idx == IDX_W'(IDX_IRQ + 2*i + 1)) begin
          irq_q[i].pol_high <= cfg_wdata[1];
          irq_q[i].lvl_trig <= cfg_wdata[0];
        end
      end
      for (int k = 0; k < NUM_DMA; k++) begin
        if (cfg_idx == IDX_W'(IDX_DMA + k)) dma_q[k] <= cfg_wdata[2:0];
      end
    end
  end

  // Read mux: unused bits and unmapped indices return zero.
  always_comb begin
    rd_val = '0;
    if (cfg_idx == IDX_ACT)  rd_val = {7'b0, act_q};
    if (cfg_idx == IDX_RCHK) rd_val = {6'b0, rc_en_q, rc_one_q};
    for (int i = 0; i < NUM_IO; i++) begin
      if (cfg_idx == IDX_W'(IDX_IO + 2*i))     rd_val = base_q[i][15:8];
      if (cfg_idx == IDX_W'(IDX_IO + 2*i + 1)) rd_val = base_q[i][7:0];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cfg_idx == IDX_W'(IDX_IRQ + 2*i))     rd_val = {4'b0, irq_q[i].level};
      if (cfg_idx == IDX_W'(IDX_IRQ + 2*i + 1)) rd_val = {6'b0, irq_q[i].pol_high, irq_q[i].lvl_trig};
    end
    for (int k = 0; k < NUM_DMA; k++) begin
      if (cfg_idx == IDX_W'(IDX_DMA + k)) rd_val = {5'b0, dma_q[k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= cfg_rd ? rd_val : '0;
  end

  assign cfg_rdata = rdata_q;
  assign active    = act_q;
  assign rc_en     = rc_en_q;
  assign rc_one    = rc_one_q;
  assign io_base   = base_q;

endmodule

// File: rtl/ldev_io_decode.sv
module ldev_io_decode
  import ldev_pkg::*;
#(
  parameter int NUM_IO   = 8,
  parameter int WIN_BITS = 3
) (
  input  logic [BASE_W-1:0]             host_addr,
  input  logic [NUM_IO-1:0][BASE_W-1:0] io_base,
  output logic [NUM_IO-1:0]             hit_vec,
  output logic                          any_hit
);

  localparam logic [BASE_W-1:0] WIN_MASK = BASE_W'((1 << WIN_BITS) - 1);

  for (genvar g = 0; g < NUM_IO; g++) begin : g_range
    assign hit_vec[g] = (io_base[g] != '0) &&
                        (((host_addr ^ io_base[g]) & ~WIN_MASK) == '0);
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/ldev_host_resp.sv
module ldev_host_resp
  import ldev_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              any_hit,
  input  logic              active,
  input  logic              rc_en,
  input  logic              rc_one,
  output logic              dev_sel,
  output logic              host_rdata_oe,
  output logic [DATA_W-1:0] host_rdata
);

  logic take_hit;
  logic test_hit;

  assign take_hit = host_rd && any_hit && active;
  assign test_hit = host_rd && any_hit && !active && rc_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_sel       <= 1'b0;
      host_rdata_oe <= 1'b0;
      host_rdata    <= '0;
    end else begin
      dev_sel       <= take_hit;
      host_rdata_oe <= test_hit;
      host_rdata    <= test_hit ? (rc_one ? PAT_ONE : PAT_ZERO) : '0;
    end
  end

endmodule

// File: rtl/ldev_resource_regs.sv
module ldev_resource_regs
  import ldev_pkg::*;
#(
  parameter int NUM_IO   = 8,
  parameter int NUM_IRQ  = 2,
  parameter int NUM_DMA  = 2,
  parameter int WIN_BITS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_reset,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        host_rd,
  input  logic [15:0] host_addr,
  output logic        dev_sel,
  output logic        host_rdata_oe,
  output logic [7:0]  host_rdata,
  output logic        dev_active
);

  logic                          active;
  logic                          rc_en;
  logic                          rc_one;
  logic [NUM_IO-1:0][BASE_W-1:0] io_base;
  logic [NUM_IO-1:0]             hit_vec;
  logic                          any_hit;

  ldev_cfg_regs #(
    .NUM_IO (NUM_IO),
    .NUM_IRQ(NUM_IRQ),
    .NUM_DMA(NUM_DMA)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_reset(cfg_reset),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .active   (active),
    .rc_en    (rc_en),
    .rc_one   (rc_one),
    .io_base  (io_base)
  );

  ldev_io_decode #(
    .NUM_IO  (NUM_IO),
    .WIN_BITS(WIN_BITS)
  ) u_dec (
    .host_addr(host_addr),
    .io_base  (io_base),
    .hit_vec  (hit_vec),
    .any_hit  (any_hit)
  );

  ldev_host_resp u_resp (
    .clk          (clk),
    .rst          (rst),
    .host_rd      (host_rd),
    .any_hit      (any_hit),
    .active       (active),
    .rc_en        (rc_en),
    .rc_one       (rc_one),
    .dev_sel      (dev_sel),
    .host_rdata_oe(host_rdata_oe),
    .host_rdata   (host_rdata)
  );

  assign dev_active = active;

endmodule

// File: rtl/ldev_resource_regs_chk.sv
module ldev_resource_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_reset,
  input logic       cfg_rd,
  input logic [7:0] cfg_rdata,
  input logic       host_rd,
  input logic       dev_sel,
  input logic       host_rdata_oe,
  input logic [7:0] host_rdata,
  input logic       dev_active
);

  p_sel_needs_active_r9: assert property (@(posedge clk) disable iff (rst)
    dev_sel |-> $past(dev_active));

  p_single_driver_r9: assert property (@(posedge clk) disable iff (rst)
    dev_sel |-> !host_rdata_oe);

  p_test_needs_idle_r10: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> !$past(dev_active));

  p_test_value_r10: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> (host_rdata == 8'h55 || host_rdata == 8'hAA));

  p_quiet_data_r10: assert property (@(posedge clk) disable iff (rst)
    !host_rdata_oe |-> host_rdata == 8'h00);

  p_no_strobe_no_resp_r8: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (!dev_sel && !host_rdata_oe));

  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> cfg_rdata == 8'h00);

  p_cfg_reset_off_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_reset |=> !dev_active);

endmodule

bind ldev_resource_regs ldev_resource_regs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_reset    (cfg_reset),
  .cfg_rd       (cfg_rd),
  .cfg_rdata    (cfg_rdata),
  .host_rd      (host_rd),
  .dev_sel      (dev_sel),
  .host_rdata_oe(host_rdata_oe),
  .host_rdata   (host_rdata),
  .dev_active   (dev_active)
);

// File: tb/ldev_resource_regs_test.sv
module ldev_resource_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_reset = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        host_rd = 1'b0;
  logic [15:0] host_addr = '0;
  logic        dev_sel;
  logic        host_rdata_oe;
  logic [7:0]  host_rdata;
  logic        dev_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldev_resource_regs uut (
    .clk(clk), .rst(rst), .cfg_reset(cfg_reset), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_rd(host_rd), .host_addr(host_addr), .dev_sel(dev_sel),
    .host_rdata_oe(host_rdata_oe), .host_rdata(host_rdata), .dev_active(dev_active)
  );

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h30, 8'hFF, 8'h01, 4'd2},  // R2 upper bits masked
    '{8'h30, 8'h00, 8'h00, 4'd2},  // R2 cleared again
    '{8'h31, 8'hFF, 8'h03, 4'd3},  // R3
    '{8'h60, 8'h12, 8'h12, 4'd4},  // R4 range 0 high
    '{8'h61, 8'h34, 8'h34, 4'd4},  // R4 range 0 low
    '{8'h6E, 8'hAB, 8'hAB, 4'd4},  // R4 range 7 high
    '{8'h6F, 8'hCD, 8'hCD, 4'd4},  // R4 range 7 low
    '{8'h70, 8'hFF, 8'h0F, 4'd5},  // R5 level
    '{8'h71, 8'hFF, 8'h03, 4'd5},  // R5 control
    '{8'h72, 8'h05, 8'h05, 4'd5},  // R5 entry 1 level
    '{8'h73, 8'h02, 8'h02, 4'd5},  // R5 entry 1 control
    '{8'h74, 8'hFF, 8'h07, 4'd6},  // R6
    '{8'h75, 8'h0B, 8'h03, 4'd6},  // R6
    '{8'h20, 8'h5A, 8'h00, 4'd7},  // R7
    '{8'h76, 8'h77, 8'h00, 4'd7},  // R7
    '{8'h5F, 8'h99, 8'h00, 4'd7}   // R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  // Returns {dev_sel, host_rdata_oe, 6'b0, host_rdata}
  task automatic host_read(input logic [15:0] a, output logic [15:0] r);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    r = {dev_sel, host_rdata_oe, 6'b0, host_rdata};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs", {12'b0, dev_sel, host_rdata_oe, dev_active, |cfg_rdata}, 16'h0);
    cfg_read(8'h30, d); chk("R1 act", {8'h0, d}, 16'h00);
    cfg_read(8'h31, d); chk("R1 rchk", {8'h0, d}, 16'h00);
    cfg_read(8'h60, d); chk("R1 io", {8'h0, d}, 16'h00);
    cfg_read(8'h71, d); chk("R1 irq", {8'h0, d}, 16'h00);
    cfg_read(8'h74, d); chk("R1 dma0", {8'h0, d}, 16'h04);
    cfg_read(8'h75, d); chk("R1 dma1", {8'h0, d}, 16'h04);

    // Vector table: write then read back
    for (int v = 0; v < NV; v++) begin
      cfg_write(VECS[v].idx, VECS[v].wd);
      cfg_read(VECS[v].idx, d);
      checks++;
      if (d !== VECS[v].exp) begin
        errors++;
        $display("FAIL R%0d idx=%h actual=%h expected=%h", VECS[v].req, VECS[v].idx, d, VECS[v].exp);
      end
    end
    cfg_read(8'h75, d); chk("R7 neighbour kept", {8'h0, d}, 16'h03);
    cfg_read(8'h60, d); chk("R7 io kept", {8'h0, d}, 16'h12);

    // R13: no read, no data
    @(negedge clk); chk("R13 idle rdata", {8'h0, cfg_rdata}, 16'h00);

    // Conflict test: range 0 = 0x1234, range 7 = 0xABCD, device inactive
    cfg_write(8'h31, 8'h03);
    host_read(16'h1230, r); chk("R10 low edge 55", r, 16'h4055);
    host_read(16'h1237, r); chk("R10 high edge 55", r, 16'h4055);
    host_read(16'h1238, r); chk("R8 past window", r, 16'h0000);
    host_read(16'h122F, r); chk("R8 below window", r, 16'h0000);
    host_read(16'hABC9, r); chk("R8 range 7", r, 16'h4055);
    host_read(16'h0003, r); chk("R8 zero base off", r, 16'h0000);
    cfg_write(8'h31, 8'h02);
    host_read(16'h1233, r); chk("R10 AA", r, 16'h40AA);
    cfg_write(8'h31, 8'h01);
    host_read(16'h1233, r); chk("R11 test off", r, 16'h0000);

    // R9 active device
    cfg_write(8'h31, 8'h00);
    cfg_write(8'h30, 8'h01);
    chk("R2 dev_active", {15'b0, dev_active}, 16'h0001);
    host_read(16'h1233, r); chk("R9 select", r, 16'h8000);
    cfg_write(8'h31, 8'h03);
    host_read(16'hABCF, r); chk("R9 select with test on", r, 16'h8000);
    host_read(16'h2000, r); chk("R9 miss", r, 16'h0000);

    // R12: config reset against a same-cycle write
    @(negedge clk);
    cfg_reset = 1'b1; cfg_wr = 1'b1; cfg_idx = 8'h74; cfg_wdata = 8'h01;
    @(negedge clk);
    cfg_reset = 1'b0; cfg_wr = 1'b0;
    chk("R12 inactive", {15'b0, dev_active}, 16'h0000);
    cfg_read(8'h74, d); chk("R12 dma0", {8'h0, d}, 16'h04);
    cfg_read(8'h60, d); chk("R12 io", {8'h0, d}, 16'h00);
    cfg_read(8'h31, d); chk("R12 rchk", {8'h0, d}, 16'h00);
    host_read(16'h1233, r); chk("R12 no decode", r, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule